// File: doc/BRIEF.md
# Masked Condition Flag Generator

This block produces the next condition-code word after an integer micro-operation. It takes the current flag word, a per-bit update mask, the operation's result, the two source operands and an operand-size code. It returns a word in which every selected flag holds a freshly derived value and every other bit is copied from the current word. The arithmetic result is computed elsewhere. For subtraction, the caller supplies the two's-complement negation of the second operand as `src_b_i`, so that carry and overflow come out of the same add-style equations.

Besides the six usual arithmetic flags, two emulation flags sit in the upper half of the word. The emulation carry flag takes the same value as carry and the emulation zero flag takes the same value as zero. Each of them has its own mask bit, so a micro-op can update a mirror without touching the architectural flag, or the reverse. The unit is purely combinational and sits in the execute stage beside the integer ALU.

Top module: `cc_flag_gen`

## Requirements
- R1: Every bit of `flags_o` whose `upd_mask_i` bit is 0 equals the same bit of `flags_i`. A mask bit that sits outside the eight flag positions (0, 2, 4, 6, 7, 11, 16, 17) has no effect, so that output bit also equals `flags_i`.
- R2: When mask bit 0 is set, bit 0 (carry) is the carry out of the top bit of the operand size. The carry vector is `(a & b) | ((a | b) & ~result)` and the bit taken from it is the size's top bit. `size_i` encodes the size as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes.
- R3: When mask bit 16 is set, bit 16 (emulation carry) takes the carry value defined in R2. This holds whether or not mask bit 0 is set.
- R4: When mask bit 4 is set, bit 4 (auxiliary carry) is the carry from bit 3 into bit 4, which equals `a[4] ^ b[4] ^ result[4]`. Its value is the same for every operand size.
- R5: When mask bit 6 is set, bit 6 (zero) is 1 exactly when the result, truncated to the operand size, is zero. When mask bit 17 is set, bit 17 (emulation zero) takes the same value.
- R6: When mask bit 7 is set, bit 7 (sign) equals the top bit of the result at the operand size.
- R7: When mask bit 11 is set, bit 11 (overflow) equals the top bit, at the operand size, of `(a ^ result) & (b ^ result)`.
- R8: When mask bit 2 is set, bit 2 (parity) is 1 exactly when `result[7:0]` holds an even number of ones. Parity uses only these 8 bits, whatever the operand size.
- R9: `flags_o` is a combinational function of the present inputs and holds no state. A new input set gives its result with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| flags_i | input | FLAG_W (32) | Current condition-code word |
| upd_mask_i | input | FLAG_W (32) | One bit per flag position to refresh |
| result_i | input | DATA_W (64) | Result of the micro-operation |
| src_a_i | input | DATA_W (64) | First source operand |
| src_b_i | input | DATA_W (64) | Second source operand (negated by the caller for subtraction) |
| size_i | input | 2 | Operand size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes |
| flags_o | output | FLAG_W (32) | Next condition-code word |

## Verification
Every flag is due in the same cycle as its stimulus, because no register lies between any input and `flags_o`. The bench therefore drives a full input set just after a falling clock edge. It samples `flags_o` a quarter period later, before the next rising edge, and never compares against a value from an earlier input set. The vector table and the directed cases cover each operand size, each flag alone under its own mask bit, the mirror flags, and mask bits at positions that hold no flag.

// File: rtl/cc_flag_pkg.sv
// Package: shared widths and flag bit positions for the condition flag generator.
// Assumes a 64-bit datapath and four operand sizes of 1, 2, 4 and 8 bytes.
package cc_flag_pkg;
    localparam int DATA_W    = 64;
    localparam int FLAG_W    = 32;
    localparam int NUM_SIZES = 4;
    localparam int SIZE_W    = $clog2(NUM_SIZES);

    // Bit positions inside the flag word.
    localparam int CF_POS  = 0;
    localparam int PF_POS  = 2;
    localparam int AF_POS  = 4;
    localparam int ZF_POS  = 6;
    localparam int SF_POS  = 7;
    localparam int OF_POS  = 11;
    localparam int ECF_POS = 16;
    localparam int EZF_POS = 17;

    // Bits of the word that this unit is allowed to rewrite.
    localparam logic [FLAG_W-1:0] FLAG_SET =
        (FLAG_W'(1) << CF_POS)  | (FLAG_W'(1) << PF_POS) |
        (FLAG_W'(1) << AF_POS)  | (FLAG_W'(1) << ZF_POS) |
        (FLAG_W'(1) << SF_POS)  | (FLAG_W'(1) << OF_POS) |
        (FLAG_W'(1) << ECF_POS) | (FLAG_W'(1) << EZF_POS);

    // Fresh values of the flags, before they are placed in the word.
    typedef struct packed {
        logic carry;
        logic parity;
        logic aux;
        logic zero;
        logic sign;
        logic ovf;
    } cc_fresh_t;
endpackage

// File: rtl/cc_size_slice.sv
// Module: cc_size_slice
// Derives the size-dependent flag bits for one operand width W.
// Assumes the carry and overflow vectors are already formed over W bits.
module cc_size_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] res_i,
    input  logic [W-1:0] cvec_i,
    input  logic [W-1:0] ovec_i,
    output logic         carry_o,
    output logic         ovf_o,
    output logic         sign_o,
    output logic         zero_o
);
    logic unused_low;

    // Take the top bits and the zero test at this width.
    always_comb begin
        carry_o    = cvec_i[W-1];
        ovf_o      = ovec_i[W-1];
        sign_o     = res_i[W-1];
        zero_o     = (res_i == '0);
        unused_low = ^{cvec_i[W-2:0], ovec_i[W-2:0]};
    end
endmodule

// File: rtl/cc_flag_eval.sv
// Module: cc_flag_eval
// Computes the fresh value of every flag from the result and sources.
// Assumes the subtraction operand arrives already negated.
module cc_flag_eval
    import cc_flag_pkg::*;
(
    input  logic [DATA_W-1:0] result_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    input  logic [SIZE_W-1:0] size_i,
    output cc_fresh_t         fresh_o
);
    logic [DATA_W-1:0]    cvec;
    logic [DATA_W-1:0]    ovec;
    logic [NUM_SIZES-1:0] carry_sz;
    logic [NUM_SIZES-1:0] ovf_sz;
    logic [NUM_SIZES-1:0] sign_sz;
    logic [NUM_SIZES-1:0] zero_sz;

    // Form the per-bit carry-out and signed-overflow vectors.
    always_comb begin
        cvec = (src_a_i & src_b_i) | ((src_a_i | src_b_i) & ~result_i);
        ovec = (src_a_i ^ result_i) & (src_b_i ^ result_i);
    end

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int SW = 8 << g;
        cc_size_slice #(.W(SW)) slice_i (
            .res_i   (result_i[SW-1:0]),
            .cvec_i  (cvec[SW-1:0]),
            .ovec_i  (ovec[SW-1:0]),
            .carry_o (carry_sz[g]),
            .ovf_o   (ovf_sz[g]),
            .sign_o  (sign_sz[g]),
            .zero_o  (zero_sz[g])
        );
    end

    // Select the active size and add the size-independent flags.
    always_comb begin
        fresh_o.carry  = carry_sz[size_i];
        fresh_o.ovf    = ovf_sz[size_i];
        fresh_o.sign   = sign_sz[size_i];
        fresh_o.zero   = zero_sz[size_i];
        fresh_o.aux    = cvec[3];
        fresh_o.parity = ~^result_i[7:0];
    end
endmodule

// File: rtl/cc_flag_merge.sv
// Module: cc_flag_merge
// Places the fresh flags in the word and keeps the bits the mask leaves alone.
// Assumes mask bits outside the flag set must be ignored.
module cc_flag_merge
    import cc_flag_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [FLAG_W-1:0] mask_i,
    input  cc_fresh_t         fresh_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] fresh_word;
    logic [FLAG_W-1:0] live_mask;

    // Build the fresh word; the mirror flags reuse carry and zero.
    always_comb begin
        fresh_word          = '0;
        fresh_word[CF_POS]  = fresh_i.carry;
        fresh_word[PF_POS]  = fresh_i.parity;
        fresh_word[AF_POS]  = fresh_i.aux;
        fresh_word[ZF_POS]  = fresh_i.zero;
        fresh_word[SF_POS]  = fresh_i.sign;
        fresh_word[OF_POS]  = fresh_i.ovf;
        fresh_word[ECF_POS] = fresh_i.carry;
        fresh_word[EZF_POS] = fresh_i.zero;
    end

    // Clear the selected positions, then insert the fresh values.
    always_comb begin
        live_mask = mask_i & FLAG_SET;
        flags_o   = (flags_i & ~live_mask) | (fresh_word & live_mask);
    end
endmodule

// File: rtl/cc_flag_gen.sv
// Module: cc_flag_gen
// Top of the masked condition flag generator; purely combinational.
// Assumes the caller negates the second operand for subtraction.
module cc_flag_gen
    import cc_flag_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [FLAG_W-1:0] upd_mask_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [FLAG_W-1:0] flags_o
);
    cc_fresh_t fresh;

    cc_flag_eval eval_i (
        .result_i (result_i),
        .src_a_i  (src_a_i),
        .src_b_i  (src_b_i),
        .size_i   (size_i),
        .fresh_o  (fresh)
    );

    cc_flag_merge merge_i (
        .flags_i  (flags_i),
        .mask_i   (upd_mask_i),
        .fresh_i  (fresh),
        .flags_o  (flags_o)
    );
endmodule

// File: rtl/cc_flag_gen_chk.sv
// Module: cc_flag_gen_chk
// Port-level checks on the flag generator, bound to every instance.
// Assumes combinational inputs settle before each evaluation.
module cc_flag_gen_chk
    import cc_flag_pkg::*;
(
    input logic [FLAG_W-1:0] flags_i,
    input logic [FLAG_W-1:0] upd_mask_i,
    input logic [DATA_W-1:0] result_i,
    input logic [DATA_W-1:0] src_a_i,
    input logic [DATA_W-1:0] src_b_i,
    input logic [SIZE_W-1:0] size_i,
    input logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] keep_mask;

    // Check relations between the ports whenever any of them moves.
    always_comb begin
        keep_mask = ~(upd_mask_i & FLAG_SET);
        // R1
        unmasked_hold_chk: assert (((flags_o ^ flags_i) & keep_mask) == '0)
            else $error("unselected flag bit changed");
        // R3
        carry_mirror_chk: assert (!(upd_mask_i[CF_POS] && upd_mask_i[ECF_POS])
                                  || (flags_o[CF_POS] == flags_o[ECF_POS]))
            else $error("emulation carry differs from carry");
        // R5
        zero_mirror_chk: assert (!(upd_mask_i[ZF_POS] && upd_mask_i[EZF_POS])
                                 || (flags_o[ZF_POS] == flags_o[EZF_POS]))
            else $error("emulation zero differs from zero");
        // R4
        aux_carry_chk: assert (!upd_mask_i[AF_POS]
                               || (flags_o[AF_POS] == (src_a_i[4] ^ src_b_i[4] ^ result_i[4])))
            else $error("auxiliary carry wrong");
        // R5
        zero_byte_chk: assert (!(upd_mask_i[ZF_POS] && size_i == '0)
                               || (flags_o[ZF_POS] == (result_i[7:0] == 8'h00)))
            else $error("byte zero flag wrong");
    end
endmodule

bind cc_flag_gen cc_flag_gen_chk chk_i (.*);

// File: tb/cc_flag_gen_tb_top.sv
// Bench: table of vectors with hand-derived expected words, then directed cases.
module cc_flag_gen_tb_top;
    import cc_flag_pkg::*;

    logic              clk = 1'b0;
    logic [FLAG_W-1:0] flags_i, upd_mask_i, flags_o;
    logic [DATA_W-1:0] result_i, src_a_i, src_b_i;
    logic [SIZE_W-1:0] size_i;
    int                n_checks = 0;
    int                n_fail = 0;
    logic              done = 1'b0;

    always #10 clk = ~clk;

    cc_flag_gen dut_i (.*);

    typedef struct packed {
        logic [31:0] old_w;
        logic [31:0] mask;
        logic [63:0] res;
        logic [63:0] a;
        logic [63:0] b;
        logic [1:0]  sz;
        logic [31:0] expw;
    } vec_t;

    localparam int NV = 13;
    localparam logic [31:0] ALL = 32'h0003_08D5;
    localparam vec_t VECS [NV] = '{
        // R2 R3 R4 R5 R8: byte wrap 0xFF+1
        '{32'h0, ALL, 64'h100, 64'hFF, 64'h01, 2'd0, 32'h0003_0055},
        // R6 R7 R4: byte 0x7F+1
        '{32'h0, ALL, 64'h80, 64'h7F, 64'h01, 2'd0, 32'h0000_0890},
        // R1 R5: only zero selected, other bits held
        '{32'hFFFF_FFFF, 32'h40, 64'h1, 64'h0, 64'h1, 2'd0, 32'hFFFF_FFBF},
        // R1: empty mask
        '{32'h1234_5678, 32'h0, 64'h0, 64'h0, 64'h0, 2'd0, 32'h1234_5678},
        // R2 R7 R5: word 0x8000+0x8000
        '{32'h0, ALL, 64'h10000, 64'h8000, 64'h8000, 2'd1, 32'h0003_0845},
        // R2 R5: same operands at 8 bytes
        '{32'h0, ALL, 64'h10000, 64'h8000, 64'h8000, 2'd3, 32'h0000_0004},
        // R6 R8: dword sign set, parity even
        '{32'h0, ALL, 64'h8000_0003, 64'h8000_0000, 64'h3, 2'd2, 32'h0000_0084},
        // R3 R5 R6: mirrors only, plus sign cleared
        '{32'h80, 32'h0003_0080, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'd3, 32'h0003_0000},
        // R7: dword overflow only
        '{32'h0, 32'h800, 64'h8000_0000, 64'h7FFF_FFFF, 64'h1, 2'd2, 32'h0000_0800},
        // R1 R6 R7: non-flag bits of old word kept under full mask
        '{32'hFFFF_FFFF, ALL, 64'h80, 64'h7F, 64'h01, 2'd0, 32'hFFFC_FFBA},
        // R1: mask bit at a non-flag position is ignored
        '{32'h2, 32'h2, 64'h0, 64'h0, 64'h0, 2'd0, 32'h0000_0002},
        // R8: odd parity clears PF
        '{32'h4, 32'h4, 64'h07, 64'h03, 64'h04, 2'd0, 32'h0000_0000},
        // R4: aux carry at word size
        '{32'h0, 32'h10, 64'h10, 64'h0F, 64'h01, 2'd1, 32'h0000_0010}
    };
    localparam string TAGS [NV] = '{"R2", "R6", "R5", "R1", "R7", "R2", "R8",
                                    "R3", "R7", "R1", "R1", "R8", "R4"};

    task automatic apply(input logic [31:0] o, input logic [31:0] m,
                         input logic [63:0] r, input logic [63:0] a,
                         input logic [63:0] b, input logic [1:0] s);
        @(negedge clk);
        flags_i = o; upd_mask_i = m; result_i = r;
        src_a_i = a; src_b_i = b; size_i = s;
        #5;
    endtask

    task automatic check(input string tag, input logic [31:0] expw);
        n_checks++;
        if (flags_o !== expw) begin
            n_fail++;
            $display("FAIL %s: flags_o=%h expected %h", tag, flags_o, expw);
        end
    endtask

    initial begin
        flags_i = '0; upd_mask_i = '0; result_i = '0;
        src_a_i = '0; src_b_i = '0; size_i = '0;
        // R9: idle inputs give the old word back in the same cycle
        apply(32'hA5A5_0000, 32'h0, 64'h0, 64'h0, 64'h0, 2'd0);
        check("R9", 32'hA5A5_0000);
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].old_w, VECS[i].mask, VECS[i].res,
                  VECS[i].a, VECS[i].b, VECS[i].sz);
            check(TAGS[i], VECS[i].expw);
        end
        // R5 R8: all-zero inputs under the full mask
        apply(32'h0, ALL, 64'h0, 64'h0, 64'h0, 2'd3);
        check("R5", 32'h0002_0044);
        // R6: sign taken from each size's top bit
        for (int s = 0; s < 4; s++) begin
            apply(32'h0, 32'h80, 64'h1 << ((8 << s) - 1), 64'h0, 64'h0, 2'(s));
            check("R6", 32'h80);
        end
        // R5: truncation decides the zero flag
        apply(32'h0, 32'h40, 64'h100, 64'h0, 64'h0, 2'd0);
        check("R5", 32'h40);
        apply(32'h0, 32'h40, 64'h100, 64'h0, 64'h0, 2'd1);
        check("R5", 32'h0);
        // R9: result follows a new input set with no extra edge
        apply(32'h0, 32'h1, 64'h0, 64'h8000_0000, 64'h8000_0000, 2'd2);
        check("R9", 32'h1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9: watchdog expired, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule